// File: doc/BRIEF.md
# Floating-Point Identification Register Access Gate

This block sits beside a read-only register that identifies the floating-point unit. It decides what happens to each read or write aimed at that register. A request is a one-cycle strobe. It carries the current privilege level (0 to 3) and the execution-state width of levels 1, 2 and 3. It also carries whether the hypervisor level is enabled, the security state and a group of trap and enable control bits. One cycle later the block returns exactly one outcome. The possible outcomes are: undefined instruction, trap to a 64-bit hypervisor, trap to a 32-bit hypervisor, read data returned, or write silently dropped. A trap outcome comes with an 8-bit syndrome code.

The identification word is fixed by parameters and is never stored from a write. Exception entry and the control registers that feed the trap bits are handled elsewhere. The block only reports which path the request must take.

Top module: `fpIdAccessGate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rspValid`, `rspOutcome`, `rspSyndrome` and `rspData` are all zero.
- R2: A request sampled with `reqValid` high at a rising edge produces `rspValid` high after that edge, for one cycle. With `rspValid` high, exactly one `rspOutcome` bit is set: bit 0 undefined, bit 1 trap to 64-bit hypervisor, bit 2 trap to 32-bit hypervisor, bit 3 read done, bit 4 write dropped. With `rspValid` low, all outputs are zero.
- R3: Any request at level 0 is undefined.
- R4: At level 1 with level 1 in 32-bit state, the request is undefined if either of two conditions holds. One is that `cpAccess` is 2'b00. The other is that level 3 is in 32-bit state, `nonSecure` is 1 and `nsCp10Access` is 0. This check has priority over every trap.
- R5: At level 1 with the hypervisor enabled and 64-bit, the request traps to the 64-bit path with syndrome 8'h07 in two cases. One is that `hostExt` is 0 and `fpTrap` is 1. The other is that `hostExt` is 1 and `fpEnable[0]` is 0.
- R6: Next at level 1, an enabled 32-bit hypervisor takes the 32-bit trap with syndrome 8'h08 in two cases. One is that `hypCp10Trap` is 1. The other is that level 3 is 32-bit, `nonSecure` is 1 and `nsCp10Access` is 0.
- R7: Last at level 1, with the hypervisor enabled, the ID-group trap gives syndrome 8'h08. `idTrap64` routes it to the 64-bit path when the hypervisor is 64-bit. `idTrap32` routes it to the 32-bit path when the hypervisor is 32-bit.
- R8: At level 2, the two FP-enable checks of R5 trap to the 64-bit path with 8'h07 without testing `hypEnabled` or the hypervisor width. After them, an enabled 32-bit hypervisor meeting the R6 condition takes the 32-bit trap with syndrome 8'h00.
- R9: At level 3, the request is undefined only when `cpAccess` is 2'b00. Level 3 never traps.
- R10: A read that passes every check returns the identification word. The word holds implementer [31:24], software-only flag [23], subarchitecture [22:16], part [15:8], variant [7:4] and revision [3:0]. `rspData` is zero for every other outcome.
- R11: A write goes through the same checks as a read. A write that passes them yields outcome bit 4 and zero data. It leaves later reads unchanged.
- R12: `rspSyndrome` is zero for the undefined, read-done and write-dropped outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| privLevel | input | 2 | Current privilege level |
| el1Is32 | input | 1 | Level 1 uses 32-bit state |
| el2Is32 | input | 1 | Level 2 uses 32-bit state |
| el3Is32 | input | 1 | Level 3 uses 32-bit state |
| hypEnabled | input | 1 | Hypervisor level enabled |
| nonSecure | input | 1 | Non-secure state flag |
| nsCp10Access | input | 1 | Non-secure coprocessor-10 access permission |
| cpAccess | input | 2 | Coprocessor access field |
| hostExt | input | 1 | Hypervisor host-extension bit |
| fpTrap | input | 1 | FP trap bit of the 64-bit hypervisor |
| fpEnable | input | 2 | FP enable field of the 64-bit hypervisor |
| hypCp10Trap | input | 1 | Coprocessor-10 trap bit of the 32-bit hypervisor |
| idTrap64 | input | 1 | ID-group trap bit, 64-bit hypervisor |
| idTrap32 | input | 1 | ID-group trap bit, 32-bit hypervisor |
| rspValid | output | 1 | Response strobe |
| rspOutcome | output | 5 | One-hot outcome |
| rspSyndrome | output | 8 | Syndrome code for trap outcomes |
| rspData | output | 32 | Read data |

## Verification
A wrong branch order in the decision tree shows up at the very next response. Either the wrong outcome bit is set, or a valid trap carries the wrong syndrome. For this reason the bench mixes random control bits with directed cases in which two checks compete, such as a 32-bit undefined condition together with a hypervisor trap. A stuck or stale response register appears as a response with no request, or as two outcome bits set. It can also appear as data leaking into a non-read outcome, which is visible in the cycle after the faulty request or in the idle cycle that follows it.

// File: rtl/fpIdAccessPkg.sv
package fpIdAccessPkg;

  localparam int SYN_W = 8;
  localparam int OUTCOME_COUNT = 5;

  typedef enum logic [2:0] {
    KIND_UNDEF    = 3'd0,
    KIND_TRAP64   = 3'd1,
    KIND_TRAP32   = 3'd2,
    KIND_READ     = 3'd3,
    KIND_WR_DROP  = 3'd4
  } outcomeKind_e;

  localparam logic [SYN_W-1:0] SYN_FP_ACCESS = 8'h07;
  localparam logic [SYN_W-1:0] SYN_ID_GROUP  = 8'h08;
  localparam logic [SYN_W-1:0] SYN_HYP_CP    = 8'h00;
  localparam logic [SYN_W-1:0] SYN_NONE      = 8'h00;

  typedef struct packed {
    logic       write;
    logic [1:0] level;
    logic       el1Is32;
    logic       el2Is32;
    logic       el3Is32;
    logic       hypEnabled;
    logic       nonSecure;
    logic       nsCp10Access;
    logic [1:0] cpAccess;
    logic       hostExt;
    logic       fpTrap;
    logic [1:0] fpEnable;
    logic       hypCp10Trap;
    logic       idTrap64;
    logic       idTrap32;
  } reqCtx_t;

  // Strobes passed from the decision logic to the response datapath.
  typedef struct packed {
    logic             load;
    outcomeKind_e     kind;
    logic [SYN_W-1:0] syndrome;
  } respStrobe_t;

  function automatic logic idWordLegal(input logic [31:0] word);
    return (word[23] == 1'b0) &&
           ((word[22:16] == 7'b0000011) || (word[22:16] == 7'b0000100));
  endfunction

endpackage

// File: rtl/fpIdAccessCtrl.sv
module fpIdAccessCtrl
  import fpIdAccessPkg::*;
(
  input  logic        reqValid,
  input  reqCtx_t     ctx,
  output respStrobe_t strobe
);

  logic nsCpBlocked;
  logic cpDenied;
  logic hyp64;
  logic hyp32;
  logic fpGate64;
  logic l1Undef;
  logic l1FpTrap;
  logic l1CpTrap32;
  logic l1IdTrap64;
  logic l1IdTrap32;
  logic l2FpTrap;
  logic l2CpTrap32;
  logic l3Undef;
  outcomeKind_e passKind;

  always_comb begin
    nsCpBlocked = ctx.el3Is32 && ctx.nonSecure && !ctx.nsCp10Access;
    cpDenied    = (ctx.cpAccess == 2'b00);
    hyp64       = ctx.hypEnabled && !ctx.el2Is32;
    hyp32       = ctx.hypEnabled && ctx.el2Is32;
    fpGate64    = (!ctx.hostExt && ctx.fpTrap) ||
                  (ctx.hostExt && !ctx.fpEnable[0]);
    l1Undef     = ctx.el1Is32 && (nsCpBlocked || cpDenied);
    l1FpTrap    = hyp64 && fpGate64;
    l1CpTrap32  = hyp32 && (nsCpBlocked || ctx.hypCp10Trap);
    l1IdTrap64  = hyp64 && ctx.idTrap64;
    l1IdTrap32  = hyp32 && ctx.idTrap32;
    l2FpTrap    = fpGate64;
    l2CpTrap32  = hyp32 && (nsCpBlocked || ctx.hypCp10Trap);
    l3Undef     = cpDenied;
    passKind    = ctx.write ? KIND_WR_DROP : KIND_READ;
  end

  always_comb begin
    strobe.load     = reqValid;
    strobe.kind     = passKind;
    strobe.syndrome = SYN_NONE;
    unique case (ctx.level)
      2'd0: begin
        strobe.kind = KIND_UNDEF;
      end
      2'd1: begin
        if (l1Undef) begin
          strobe.kind = KIND_UNDEF;
        end else if (l1FpTrap) begin
          strobe.kind     = KIND_TRAP64;
          strobe.syndrome = SYN_FP_ACCESS;
        end else if (l1CpTrap32) begin
          strobe.kind     = KIND_TRAP32;
          strobe.syndrome = SYN_ID_GROUP;
        end else if (l1IdTrap64) begin
          strobe.kind     = KIND_TRAP64;
          strobe.syndrome = SYN_ID_GROUP;
        end else if (l1IdTrap32) begin
          strobe.kind     = KIND_TRAP32;
          strobe.syndrome = SYN_ID_GROUP;
        end
      end
      2'd2: begin
        if (l2FpTrap) begin
          strobe.kind     = KIND_TRAP64;
          strobe.syndrome = SYN_FP_ACCESS;
        end else if (l2CpTrap32) begin
          strobe.kind     = KIND_TRAP32;
          strobe.syndrome = SYN_HYP_CP;
        end
      end
      default: begin
        if (l3Undef) strobe.kind = KIND_UNDEF;
      end
    endcase
  end

endmodule

// File: rtl/fpIdAccessData.sv
module fpIdAccessData
  import fpIdAccessPkg::*;
#(
  parameter int               DATA_W  = 32,
  parameter logic [DATA_W-1:0] ID_WORD = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  respStrobe_t              strobe,
  output logic                     rspValid,
  output logic [OUTCOME_COUNT-1:0] rspOutcome,
  output logic [SYN_W-1:0]         rspSyndrome,
  output logic [DATA_W-1:0]        rspData
);

  logic             validQ;
  outcomeKind_e     kindQ;
  logic [SYN_W-1:0] synQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      kindQ  <= KIND_UNDEF;
      synQ   <= '0;
    end else begin
      validQ <= strobe.load;
      if (strobe.load) begin
        kindQ <= strobe.kind;
        synQ  <= strobe.syndrome;
      end
    end
  end

  for (genvar i = 0; i < OUTCOME_COUNT; i++) begin : gOutcome
    assign rspOutcome[i] = validQ && (kindQ == outcomeKind_e'(i));
  end

  assign rspValid    = validQ;
  assign rspSyndrome = validQ ? synQ : '0;
  assign rspData     = (validQ && kindQ == KIND_READ) ? ID_WORD : '0;

endmodule

// File: rtl/fpIdAccessGate.sv
module fpIdAccessGate
  import fpIdAccessPkg::*;
#(
  parameter logic [7:0] IMPLEMENTER = 8'h5A,
  parameter logic       SW_ONLY     = 1'b0,
  parameter logic [6:0] SUBARCH     = 7'b0000011,
  parameter logic [7:0] PART_NUM    = 8'hC3,
  parameter logic [3:0] VARIANT_NUM = 4'h2,
  parameter logic [3:0] REV_NUM     = 4'h7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  privLevel,
  input  logic        el1Is32,
  input  logic        el2Is32,
  input  logic        el3Is32,
  input  logic        hypEnabled,
  input  logic        nonSecure,
  input  logic        nsCp10Access,
  input  logic [1:0]  cpAccess,
  input  logic        hostExt,
  input  logic        fpTrap,
  input  logic [1:0]  fpEnable,
  input  logic        hypCp10Trap,
  input  logic        idTrap64,
  input  logic        idTrap32,
  output logic        rspValid,
  output logic [4:0]  rspOutcome,
  output logic [7:0]  rspSyndrome,
  output logic [31:0] rspData
);

  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] ID_WORD =
    {IMPLEMENTER, SW_ONLY, SUBARCH, PART_NUM, VARIANT_NUM, REV_NUM};

  if (!idWordLegal(ID_WORD)) begin : gBadId
    $error("identification word parameters are not legal");
  end

  reqCtx_t     ctx;
  respStrobe_t strobe;

  always_comb begin
    ctx.write        = reqWrite;
    ctx.level        = privLevel;
    ctx.el1Is32      = el1Is32;
    ctx.el2Is32      = el2Is32;
    ctx.el3Is32      = el3Is32;
    ctx.hypEnabled   = hypEnabled;
    ctx.nonSecure    = nonSecure;
    ctx.nsCp10Access = nsCp10Access;
    ctx.cpAccess     = cpAccess;
    ctx.hostExt      = hostExt;
    ctx.fpTrap       = fpTrap;
    ctx.fpEnable     = fpEnable;
    ctx.hypCp10Trap  = hypCp10Trap;
    ctx.idTrap64     = idTrap64;
    ctx.idTrap32     = idTrap32;
  end

  fpIdAccessCtrl uCtrl (
    .reqValid (reqValid),
    .ctx      (ctx),
    .strobe   (strobe)
  );

  fpIdAccessData #(
    .DATA_W  (DATA_W),
    .ID_WORD (ID_WORD)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rspValid    (rspValid),
    .rspOutcome  (rspOutcome),
    .rspSyndrome (rspSyndrome),
    .rspData     (rspData)
  );

endmodule

// File: rtl/fpIdAccessGateChecker.sv
module fpIdAccessGateChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  privLevel,
  input logic        rspValid,
  input logic [4:0]  rspOutcome,
  input logic [7:0]  rspSyndrome,
  input logic [31:0] rspData
);

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones(rspOutcome) == 1);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspOutcome == 5'd0 && rspSyndrome == 8'd0 && rspData == 32'd0));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_level0_undef_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && privLevel == 2'd0) |=> rspOutcome[0]);

  p_level3_no_trap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && privLevel == 2'd3) |=> (rspOutcome[2:1] == 2'b00));

  p_data_on_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rspOutcome[3] |-> rspData == 32'd0);

  p_quiet_syndrome_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rspOutcome[0] || rspOutcome[3] || rspOutcome[4]) |-> rspSyndrome == 8'd0);

endmodule

bind fpIdAccessGate fpIdAccessGateChecker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .privLevel   (privLevel),
  .rspValid    (rspValid),
  .rspOutcome  (rspOutcome),
  .rspSyndrome (rspSyndrome),
  .rspData     (rspData)
);

// File: tb/fpIdAccessGate_test.sv
module fpIdAccessGate_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXP_ID = {8'h5A, 1'b0, 7'b0000011, 8'hC3, 4'h2, 4'h7};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] privLevel = 2'd0;
  logic el1Is32 = 1'b0, el2Is32 = 1'b0, el3Is32 = 1'b0;
  logic hypEnabled = 1'b0, nonSecure = 1'b0, nsCp10Access = 1'b0;
  logic [1:0] cpAccess = 2'd0;
  logic hostExt = 1'b0, fpTrap = 1'b0;
  logic [1:0] fpEnable = 2'd0;
  logic hypCp10Trap = 1'b0, idTrap64 = 1'b0, idTrap32 = 1'b0;
  logic rspValid;
  logic [4:0] rspOutcome;
  logic [7:0] rspSyndrome;
  logic [31:0] rspData;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fpIdAccessGate uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .privLevel(privLevel), .el1Is32(el1Is32), .el2Is32(el2Is32), .el3Is32(el3Is32),
    .hypEnabled(hypEnabled), .nonSecure(nonSecure), .nsCp10Access(nsCp10Access),
    .cpAccess(cpAccess), .hostExt(hostExt), .fpTrap(fpTrap), .fpEnable(fpEnable),
    .hypCp10Trap(hypCp10Trap), .idTrap64(idTrap64), .idTrap32(idTrap32),
    .rspValid(rspValid), .rspOutcome(rspOutcome), .rspSyndrome(rspSyndrome),
    .rspData(rspData)
  );

  // Expected outcome index (0..4) and syndrome, from the requirements.
  function automatic logic [10:0] expect_result();
    logic nsBlk, hyp64, hyp32, gate;
    nsBlk = el3Is32 && nonSecure && !nsCp10Access;
    hyp64 = hypEnabled && !el2Is32;
    hyp32 = hypEnabled && el2Is32;
    gate  = (!hostExt && fpTrap) || (hostExt && !fpEnable[0]);
    case (privLevel)
      2'd0: return {3'd0, 8'h00};                                   // R3
      2'd1: begin
        if (el1Is32 && (nsBlk || cpAccess == 2'b00)) return {3'd0, 8'h00}; // R4
        if (hyp64 && gate) return {3'd1, 8'h07};                    // R5
        if (hyp32 && (nsBlk || hypCp10Trap)) return {3'd2, 8'h08};  // R6
        if (hyp64 && idTrap64) return {3'd1, 8'h08};                // R7
        if (hyp32 && idTrap32) return {3'd2, 8'h08};                // R7
      end
      2'd2: begin
        if (gate) return {3'd1, 8'h07};                             // R8
        if (hyp32 && (nsBlk || hypCp10Trap)) return {3'd2, 8'h00};  // R8
      end
      default: if (cpAccess == 2'b00) return {3'd0, 8'h00};         // R9
    endcase
    return {(reqWrite ? 3'd4 : 3'd3), 8'h00};                        // R10 R11
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input string req);
    logic [10:0] e;
    logic [4:0] expOut;
    @(negedge clk);
    e = expect_result();
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    expOut = 5'd1 << e[10:8];
    check({req, " valid"}, 64'(rspValid), 64'd1);
    check({req, " outcome"}, 64'(rspOutcome), 64'(expOut));
    check({req, " syndrome R12"}, 64'(rspSyndrome), 64'(e[7:0]));
    check({req, " data R10"}, 64'(rspData), (e[10:8] == 3'd3) ? 64'(EXP_ID) : 64'd0);
  endtask

  task automatic clear_ctl();
    reqWrite = 0; el1Is32 = 0; el2Is32 = 0; el3Is32 = 0; hypEnabled = 0;
    nonSecure = 0; nsCp10Access = 1; cpAccess = 2'b11; hostExt = 0; fpTrap = 0;
    fpEnable = 2'b11; hypCp10Trap = 0; idTrap64 = 0; idTrap32 = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    clear_ctl();
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(rspValid), 64'd0);
    check("R1 reset outputs", {rspOutcome, rspSyndrome, rspData}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {rspValid, rspOutcome, rspSyndrome, rspData}, 64'd0);

    privLevel = 2'd0; issue("R3 level0 read");
    reqWrite = 1; issue("R3 level0 write"); clear_ctl();

    privLevel = 2'd1; el1Is32 = 1; cpAccess = 2'b00; hypEnabled = 1; fpTrap = 1;
    issue("R4 cp denied beats trap");
    cpAccess = 2'b01; el3Is32 = 1; nonSecure = 1; nsCp10Access = 0;
    issue("R4 ns blocked");
    el1Is32 = 0; issue("R5 64-bit el1 falls to fp trap");
    clear_ctl(); privLevel = 2'd1; el1Is32 = 1; cpAccess = 2'b00;
    issue("R4 cp denied undef");
    el1Is32 = 0; issue("R10 64-bit el1 ignores cp field");

    clear_ctl(); privLevel = 2'd1; hypEnabled = 1; hostExt = 1; fpEnable = 2'b10;
    issue("R5 fp enable bit0 clear");
    fpEnable = 2'b01; issue("R5 fp enable bit0 set passes");
    hypEnabled = 0; hostExt = 0; fpTrap = 1; issue("R5 hyp disabled no trap");

    clear_ctl(); privLevel = 2'd1; hypEnabled = 1; el2Is32 = 1; hypCp10Trap = 1;
    idTrap32 = 1; issue("R6 cp10 trap beats id trap");
    hypCp10Trap = 0; issue("R7 id trap 32");
    el2Is32 = 0; idTrap32 = 1; issue("R7 idTrap32 ignored for 64-bit hyp");
    idTrap64 = 1; issue("R7 id trap 64");

    clear_ctl(); privLevel = 2'd2; fpTrap = 1; issue("R8 fp trap without enable");
    fpTrap = 0; hypEnabled = 1; el2Is32 = 1; hypCp10Trap = 1;
    issue("R8 hyp cp trap code zero");
    hypCp10Trap = 0; idTrap32 = 1; issue("R8 id trap not at level2");

    clear_ctl(); privLevel = 2'd3; cpAccess = 2'b00; fpTrap = 1;
    issue("R9 level3 cp denied");
    cpAccess = 2'b01; hypEnabled = 1; el2Is32 = 1; hypCp10Trap = 1;
    issue("R9 level3 read");

    reqWrite = 1; issue("R11 write dropped");
    reqWrite = 0; issue("R11 read after write");
    @(negedge clk);
    check("R2 idle after response", {rspValid, rspOutcome, rspSyndrome, rspData}, 64'd0);

    for (int i = 0; i < 3000; i++) begin
      {reqWrite, el1Is32, el2Is32, el3Is32, hypEnabled, nonSecure, nsCp10Access,
       hostExt, fpTrap, hypCp10Trap, idTrap64, idTrap32} = 12'($urandom);
      privLevel = 2'($urandom);
      cpAccess = 2'($urandom);
      fpEnable = 2'($urandom);
      issue("R2 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule